// File: doc/BRIEF.md
# Biphase Line Data Capture Decoder

This block is the digital back end of a video line data slicer. An analog front end and a sync extractor are assumed to deliver a sliced one-bit data stream and two window strobes. One strobe is high during the line that carries the programme-delivery payload. The other is high during the half line that carries the widescreen signalling word. The block samples the stream once per clock of a nominal 5 MHz sample clock, which gives exactly two samples per 2.5 Mbit/s biphase symbol. It decodes symbols, hunts for a framing pattern, and then captures the payload of whichever window is open.

In programme mode, the bytes that follow the framing code are numbered from 3 upwards. Bytes 5, 11, 12, 13 and 14 are kept in five payload slots. In widescreen mode, the 14 bits that follow the framing code form one word. A frame-found flag per mode and one error flag per payload slot report the outcome. These flags hold their value until software pulses the clear input. A slot whose byte arrived damaged keeps its previous contents.

Top module: `vbi_line_decoder`

## Requirements
- R1: After reset, every output is 0: the payload slots, the widescreen word, both frame flags and all error flags.
- R2: A symbol is two consecutive samples. The first sample is the data bit, and the second must be its complement: a 1 is sent as 1 then 0, and a 0 as 0 then 1. Payload bytes arrive most significant bit first.
- R3: While winVps is high, once the last 16 decoded bits equal 0x9951 (sent most significant bit first), frmVps becomes 1. The next bytes are numbered 3, 4 and so on. Bytes 5, 11, 12, 13 and 14 are written to slots 0 to 4, and slot k occupies vpsPayload[8k+7:8k].
- R4: While winWss is high, once the last 24 decoded bits equal 0x1E3C1F, frmWss becomes 1. The next 14 decoded bits form wssWord, and the first bit received lands in wssWord[0].
- R5: If the framing code does not appear within a window, no payload or word changes and the frame flag of that mode stays 0.
- R6: A symbol with two equal samples after framing is a biphase error. For a programme byte in slot k, it sets errFlags[k+1] and leaves slot k unchanged. For the widescreen word, it sets errFlags[1] and leaves wssWord unchanged.
- R7: A captured byte or word with no biphase error is stored and leaves its error flag unchanged. Bytes that are not captured never touch any flag or slot.
- R8: Frame flags and error flags are sticky. They keep their value across later windows until a one-cycle pulse on clr clears them all. If a flag is set in the same cycle as a clear, the set wins.
- R9: Before framing, a symbol with equal halves moves the symbol boundary by one sample. A stream that starts one sample late therefore still locks on its run-in and decodes correctly.
- R10: If the window falls in the middle of a payload, capture stops. Slots whose byte was not complete keep their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock, one sample per edge |
| rstN | input | 1 | Asynchronous active-low reset |
| winVps | input | 1 | Programme data line window |
| winWss | input | 1 | Widescreen half-line window |
| dataIn | input | 1 | Sliced serial data |
| clr | input | 1 | Software clear pulse for all flags |
| vpsPayload | output | 40 | Five captured programme bytes, slot k at bits 8k+7:8k |
| wssWord | output | 14 | Captured widescreen word |
| frmVps | output | 1 | Programme framing found (sticky) |
| frmWss | output | 1 | Widescreen framing found (sticky) |
| errFlags | output | 5 | Per-slot biphase error flags, indices 5 to 1 (sticky) |

## Verification
The assertions take for granted that the two windows are never high together and that a store can only happen while the matching window is open. They also assume that every window opens on a clean line with an alternating run-in ahead of its framing code. The stimulus opens one window at a time, with idle cycles between windows. It drives one sample per clock away from the sampling edge. It always sends a run-in of alternating bits before the framing code, so that the one-sample slip can settle before any code bit arrives. Errors are injected only as equal-half symbols, and the data that follows an error is sent in correct alignment.

// File: rtl/vbi_dec_pkg.sv
package vbi_dec_pkg;

  localparam int SLOT_W = 3;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_HUNT,
    ST_CAP,
    ST_DONE
  } dec_state_e;

  typedef enum logic {
    MODE_VPS,
    MODE_WSS
  } dec_mode_e;

  // control -> datapath strobes
  typedef struct packed {
    logic              active;
    logic              hunt;
    logic              storeByte;
    logic [SLOT_W-1:0] slot;
    logic              storeWss;
    logic              setFrmVps;
    logic              setFrmWss;
    logic              setErr;
    logic [SLOT_W-1:0] errSlot;
  } dec_ctrl_t;

  // datapath -> control status
  typedef struct packed {
    logic symStrobe;
    logic symErr;
    logic matchVps;
    logic matchWss;
  } dec_stat_t;

endpackage

// File: rtl/vbi_dec_dp.sv
module vbi_dec_dp
  import vbi_dec_pkg::*;
#(
  parameter int NUM_BYTES = 5,
  parameter int WSS_BITS = 14,
  parameter int VPS_CODE_W = 16,
  parameter int WSS_CODE_W = 24,
  parameter logic [VPS_CODE_W-1:0] VPS_CODE = 16'h9951,
  parameter logic [WSS_CODE_W-1:0] WSS_CODE = 24'h1E3C1F
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   dataIn,
  input  logic                   clr,
  input  dec_ctrl_t              ctrl,
  output dec_stat_t              stat,
  output logic [NUM_BYTES*8-1:0] payload,
  output logic [WSS_BITS-1:0]    wssWord,
  output logic                   frmVps,
  output logic                   frmWss,
  output logic [NUM_BYTES-1:0]   errBits
);

  localparam int SR_W = (VPS_CODE_W > WSS_CODE_W) ? VPS_CODE_W : WSS_CODE_W;

  logic                phase;
  logic                firstHalf;
  logic [SR_W-1:0]     huntSr;
  logic [SR_W-1:0]     huntNext;
  logic [7:0]          byteSr;
  logic [7:0]          byteNext;
  logic [WSS_BITS-1:0] wssSr;
  logic [WSS_BITS-1:0] wssNext;

  // symbol decode: first half carries the bit, second half must differ
  always_comb begin
    stat.symStrobe = ctrl.active & phase;
    stat.symErr    = ctrl.active & phase & (firstHalf == dataIn);
    huntNext       = {huntSr[SR_W-2:0], firstHalf};
    stat.matchVps  = stat.symStrobe & ~stat.symErr & ctrl.hunt &
                     (huntNext[VPS_CODE_W-1:0] == VPS_CODE);
    stat.matchWss  = stat.symStrobe & ~stat.symErr & ctrl.hunt &
                     (huntNext[WSS_CODE_W-1:0] == WSS_CODE);
    byteNext       = {byteSr[6:0], firstHalf};
    wssNext        = {firstHalf, wssSr[WSS_BITS-1:1]};
  end

  // half-symbol phase tracking with one-sample slip while hunting
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase     <= 1'b0;
      firstHalf <= 1'b0;
    end else if (!ctrl.active) begin
      phase     <= 1'b0;
    end else if (!phase) begin
      firstHalf <= dataIn;
      phase     <= 1'b1;
    end else if (stat.symErr && ctrl.hunt) begin
      firstHalf <= dataIn;
    end else begin
      phase     <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      huntSr <= '0;
    end else if (!ctrl.active) begin
      huntSr <= '0;
    end else if (stat.symStrobe && ctrl.hunt) begin
      huntSr <= stat.symErr ? '0 : huntNext;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      byteSr <= '0;
      wssSr  <= '0;
    end else if (stat.symStrobe && !ctrl.hunt) begin
      byteSr <= byteNext;
      wssSr  <= wssNext;
    end
  end

  generate
    for (genvar k = 0; k < NUM_BYTES; k++) begin : g_slot
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          payload[k*8 +: 8] <= '0;
        end else if (ctrl.storeByte && ctrl.slot == SLOT_W'(k)) begin
          payload[k*8 +: 8] <= byteNext;
        end
      end

      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          errBits[k] <= 1'b0;
        end else if (ctrl.setErr && ctrl.errSlot == SLOT_W'(k)) begin
          errBits[k] <= 1'b1;
        end else if (clr) begin
          errBits[k] <= 1'b0;
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wssWord <= '0;
    end else if (ctrl.storeWss) begin
      wssWord <= wssNext;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      frmVps <= 1'b0;
      frmWss <= 1'b0;
    end else begin
      if (ctrl.setFrmVps)      frmVps <= 1'b1;
      else if (clr)            frmVps <= 1'b0;
      if (ctrl.setFrmWss)      frmWss <= 1'b1;
      else if (clr)            frmWss <= 1'b0;
    end
  end

endmodule

// File: rtl/vbi_dec_ctrl.sv
module vbi_dec_ctrl
  import vbi_dec_pkg::*;
#(
  parameter int NUM_BYTES = 5,
  parameter int WSS_BITS = 14,
  parameter int FIRST_BYTE = 3,
  parameter int SOLO_BYTE = 5,
  parameter int RUN_BYTE = 11
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      winVps,
  input  logic      winWss,
  input  dec_stat_t stat,
  output dec_ctrl_t ctrl
);

  localparam int LAST_BYTE = RUN_BYTE + NUM_BYTES - 2;
  localparam int MAX_BITS  = (WSS_BITS > 8) ? WSS_BITS : 8;
  localparam int CNT_W     = $clog2(MAX_BITS);
  localparam int BN_W      = $clog2(LAST_BYTE + 1);

  dec_state_e       state;
  dec_mode_e        mode;
  logic [CNT_W-1:0] bitCnt;
  logic [BN_W-1:0]  byteNum;
  logic             grpBad;

  logic              isVps;
  logic              winOn;
  logic              bad;
  logic              lastBit;
  logic              inSet;
  logic [SLOT_W-1:0] slotIdx;

  always_comb begin
    isVps   = (state == ST_IDLE) ? winVps : (mode == MODE_VPS);
    winOn   = isVps ? winVps : winWss;
    bad     = grpBad | stat.symErr;
    lastBit = isVps ? (bitCnt == CNT_W'(7)) : (bitCnt == CNT_W'(WSS_BITS - 1));
  end

  // byte number to payload slot
  always_comb begin
    inSet   = 1'b0;
    slotIdx = '0;
    if (byteNum == BN_W'(SOLO_BYTE)) begin
      inSet = 1'b1;
    end else if (byteNum >= BN_W'(RUN_BYTE) && byteNum <= BN_W'(LAST_BYTE)) begin
      inSet   = 1'b1;
      slotIdx = SLOT_W'(byteNum - BN_W'(RUN_BYTE)) + SLOT_W'(1);
    end
  end

  always_comb begin
    ctrl        = '0;
    ctrl.active = winOn;
    ctrl.hunt   = (state == ST_IDLE) || (state == ST_HUNT);
    if (winOn) begin
      case (state)
        ST_HUNT: begin
          ctrl.setFrmVps = isVps & stat.matchVps;
          ctrl.setFrmWss = ~isVps & stat.matchWss;
        end
        ST_CAP: begin
          if (stat.symStrobe && lastBit) begin
            if (isVps) begin
              if (inSet) begin
                ctrl.storeByte = ~bad;
                ctrl.slot      = slotIdx;
                ctrl.setErr    = bad;
                ctrl.errSlot   = slotIdx;
              end
            end else begin
              ctrl.storeWss = ~bad;
              ctrl.setErr   = bad;
              ctrl.errSlot  = '0;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      mode    <= MODE_VPS;
      bitCnt  <= '0;
      byteNum <= '0;
      grpBad  <= 1'b0;
    end else if (!winOn) begin
      state  <= ST_IDLE;
      grpBad <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          state <= ST_HUNT;
          mode  <= winVps ? MODE_VPS : MODE_WSS;
        end
        ST_HUNT: begin
          if (ctrl.setFrmVps || ctrl.setFrmWss) begin
            state   <= ST_CAP;
            bitCnt  <= '0;
            byteNum <= BN_W'(FIRST_BYTE);
            grpBad  <= 1'b0;
          end
        end
        ST_CAP: begin
          if (stat.symStrobe) begin
            if (lastBit) begin
              bitCnt <= '0;
              grpBad <= 1'b0;
              if (isVps) begin
                byteNum <= byteNum + BN_W'(1);
                if (byteNum == BN_W'(LAST_BYTE)) state <= ST_DONE;
              end else begin
                state <= ST_DONE;
              end
            end else begin
              bitCnt <= bitCnt + CNT_W'(1);
              grpBad <= bad;
            end
          end
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/vbi_line_decoder.sv
module vbi_line_decoder
  import vbi_dec_pkg::*;
#(
  parameter int NUM_BYTES = 5,
  parameter int WSS_BITS = 14,
  parameter int VPS_CODE_W = 16,
  parameter int WSS_CODE_W = 24,
  parameter logic [VPS_CODE_W-1:0] VPS_CODE = 16'h9951,
  parameter logic [WSS_CODE_W-1:0] WSS_CODE = 24'h1E3C1F,
  parameter int FIRST_BYTE = 3,
  parameter int SOLO_BYTE = 5,
  parameter int RUN_BYTE = 11
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   winVps,
  input  logic                   winWss,
  input  logic                   dataIn,
  input  logic                   clr,
  output logic [NUM_BYTES*8-1:0] vpsPayload,
  output logic [WSS_BITS-1:0]    wssWord,
  output logic                   frmVps,
  output logic                   frmWss,
  output logic [NUM_BYTES:1]     errFlags
);

  dec_ctrl_t                ctrl;
  dec_stat_t                stat;
  logic [NUM_BYTES-1:0]     errBits;

  vbi_dec_ctrl #(
    .NUM_BYTES (NUM_BYTES),
    .WSS_BITS  (WSS_BITS),
    .FIRST_BYTE(FIRST_BYTE),
    .SOLO_BYTE (SOLO_BYTE),
    .RUN_BYTE  (RUN_BYTE)
  ) u_ctrl (
    .clk   (clk),
    .rstN  (rstN),
    .winVps(winVps),
    .winWss(winWss),
    .stat  (stat),
    .ctrl  (ctrl)
  );

  vbi_dec_dp #(
    .NUM_BYTES (NUM_BYTES),
    .WSS_BITS  (WSS_BITS),
    .VPS_CODE_W(VPS_CODE_W),
    .WSS_CODE_W(WSS_CODE_W),
    .VPS_CODE  (VPS_CODE),
    .WSS_CODE  (WSS_CODE)
  ) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .dataIn (dataIn),
    .clr    (clr),
    .ctrl   (ctrl),
    .stat   (stat),
    .payload(vpsPayload),
    .wssWord(wssWord),
    .frmVps (frmVps),
    .frmWss (frmWss),
    .errBits(errBits)
  );

  assign errFlags = errBits;

endmodule

// File: rtl/vbi_dec_chk.sv
module vbi_dec_chk #(
  parameter int NUM_BYTES = 5,
  parameter int WSS_BITS = 14
) (
  input logic                   clk,
  input logic                   rstN,
  input logic                   winVps,
  input logic                   winWss,
  input logic                   clr,
  input logic [NUM_BYTES*8-1:0] vpsPayload,
  input logic [WSS_BITS-1:0]    wssWord,
  input logic                   frmVps,
  input logic                   frmWss,
  input logic [NUM_BYTES:1]     errFlags
);

  // input assumption: one window at a time (R3, R4)
  assert_windows_exclusive_R3: assert property (@(posedge clk) disable iff (!rstN)
    !(winVps && winWss));

  assert_frm_vps_window_R3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(frmVps) |-> $past(winVps));

  assert_frm_wss_window_R4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(frmWss) |-> $past(winWss));

  assert_payload_window_R3: assert property (@(posedge clk) disable iff (!rstN)
    (vpsPayload != $past(vpsPayload)) |-> $past(winVps));

  assert_wss_window_R4: assert property (@(posedge clk) disable iff (!rstN)
    (wssWord != $past(wssWord)) |-> $past(winWss));

  assert_err_rise_window_R6: assert property (@(posedge clk) disable iff (!rstN)
    ((errFlags & ~$past(errFlags)) != '0) |-> $past(winVps || winWss));

  assert_err_sticky_R8: assert property (@(posedge clk) disable iff (!rstN)
    !$past(clr) |-> ((errFlags & $past(errFlags)) == $past(errFlags)));

  assert_frm_sticky_R8: assert property (@(posedge clk) disable iff (!rstN)
    (!$past(clr) && $past(frmVps)) |-> frmVps);

endmodule

bind vbi_line_decoder vbi_dec_chk #(
  .NUM_BYTES(NUM_BYTES),
  .WSS_BITS (WSS_BITS)
) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .winVps    (winVps),
  .winWss    (winWss),
  .clr       (clr),
  .vpsPayload(vpsPayload),
  .wssWord   (wssWord),
  .frmVps    (frmVps),
  .frmWss    (frmWss),
  .errFlags  (errFlags)
);

// File: tb/vbi_line_decoder_tb.sv
`timescale 1ns/1ps
module vbi_line_decoder_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        winVps = 1'b0;
  logic        winWss = 1'b0;
  logic        dataIn = 1'b0;
  logic        clr = 1'b0;
  logic [39:0] vpsPayload;
  logic [13:0] wssWord;
  logic        frmVps;
  logic        frmWss;
  logic [5:1]  errFlags;

  int tests = 0;
  int fails = 0;
  bit done = 0;

  logic [7:0]  expPay [5];
  logic [13:0] expWss;
  logic        expFrmV, expFrmW;
  logic [5:1]  expErr;

  always #2.5 clk = ~clk;

  vbi_line_decoder u_dut (
    .clk(clk), .rstN(rstN), .winVps(winVps), .winWss(winWss),
    .dataIn(dataIn), .clr(clr), .vpsPayload(vpsPayload), .wssWord(wssWord),
    .frmVps(frmVps), .frmWss(frmWss), .errFlags(errFlags)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // payload byte number -> slot, -1 when not kept (R3)
  function automatic int slotOf(input int b);
    if (b == 5) return 0;
    if (b >= 11 && b <= 14) return b - 10;
    return -1;
  endfunction

  task automatic checkAll(input string req);
    for (int k = 0; k < 5; k++) check(req, 64'(vpsPayload[k*8 +: 8]), 64'(expPay[k]));
    check(req, 64'(wssWord), 64'(expWss));
    check(req, 64'(frmVps), 64'(expFrmV));
    check(req, 64'(frmWss), 64'(expFrmW));
    check(req, 64'(errFlags), 64'(expErr));
  endtask

  task automatic sendSample(input logic b);
    dataIn = b;
    @(negedge clk);
  endtask

  task automatic sendSym(input logic b, input bit bad);
    sendSample(b);
    sendSample(bad ? b : ~b);
  endtask

  task automatic sendBits(input logic [31:0] v, input int n);
    for (int i = n - 1; i >= 0; i--) sendSym(v[i], 0);
  endtask

  task automatic runIn(input int n);
    for (int i = 0; i < n; i++) sendSym((i % 2) == 0, 0);
  endtask

  task automatic closeWindow();
    winVps = 1'b0;
    winWss = 1'b0;
    dataIn = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic clearFlags();
    clr = 1'b1;
    @(negedge clk);
    clr = 1'b0;
    expErr = '0;
    expFrmV = 1'b0;
    expFrmW = 1'b0;
    @(negedge clk);
  endtask

  // programme line: bytes 3..lastByte, then partBits of the next byte
  task automatic doVps(input bit offset, input bit frameOk, input int errByte,
                       input int lastByte, input int partBits);
    logic [7:0] b;
    winVps = 1'b1;
    if (offset) sendSample(1'b0);
    runIn(12);
    sendBits(frameOk ? 32'h9951 : 32'h9953, 16);
    if (frameOk) begin
      expFrmV = 1'b1;
      for (int n = 3; n <= lastByte; n++) begin
        b = 8'($urandom);
        for (int i = 7; i >= 0; i--) sendSym(b[i], (n == errByte) && (i == 3));
        if (slotOf(n) >= 0) begin
          if (n == errByte) expErr[slotOf(n) + 1] = 1'b1;
          else expPay[slotOf(n)] = b;
        end
      end
      b = 8'($urandom);
      for (int i = 7; i > 7 - partBits; i--) sendSym(b[i], 0);
    end
    closeWindow();
  endtask

  task automatic doWss(input bit offset, input bit frameOk, input int errBit);
    logic [13:0] w;
    winWss = 1'b1;
    if (offset) sendSample(1'b0);
    runIn(12);
    sendBits(frameOk ? 32'h1E3C1F : 32'h1E3C1E, 24);
    if (frameOk) begin
      expFrmW = 1'b1;
      w = 14'($urandom);
      for (int i = 0; i < 14; i++) sendSym(w[i], i == errBit);
      if (errBit >= 0) expErr[1] = 1'b1;
      else expWss = w;
    end
    closeWindow();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      tests++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1357));
    for (int k = 0; k < 5; k++) expPay[k] = '0;
    expWss = '0; expFrmV = 0; expFrmW = 0; expErr = '0;
    repeat (4) @(negedge clk);
    checkAll("R1 reset state");
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    doVps(0, 1, -1, 15, 0);  checkAll("R2 R3 R7 clean programme line");
    doVps(1, 1, -1, 15, 0);  checkAll("R9 late-by-one-sample line");
    doVps(0, 1, 12, 15, 0);  checkAll("R6 error in byte 12");
    doVps(0, 1, 4, 15, 0);   checkAll("R7 error in uncaptured byte, R8 flag held");
    clearFlags();            checkAll("R8 clear pulse");
    doWss(0, 1, -1);         checkAll("R4 clean widescreen word");
    doWss(1, 1, 13);         checkAll("R6 widescreen error in last bit");
    clearFlags();
    doVps(0, 0, -1, 15, 0);  checkAll("R5 programme framing absent");
    doWss(0, 0, -1);         checkAll("R5 widescreen framing absent");
    doVps(0, 1, -1, 11, 4);  checkAll("R10 window drop mid byte 12");

    for (int t = 0; t < 24; t++) begin
      if ($urandom_range(0, 3) == 0) clearFlags();
      if ($urandom_range(0, 1) == 0)
        doVps(1'($urandom_range(0, 1)), $urandom_range(0, 9) != 0,
              ($urandom_range(0, 1) == 0) ? -1 : int'($urandom_range(3, 15)), 15, 0);
      else
        doWss(1'($urandom_range(0, 1)), $urandom_range(0, 9) != 0,
              ($urandom_range(0, 2) == 0) ? int'($urandom_range(0, 13)) : -1);
      checkAll("R3 R4 R6 R8 random line");
    end

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule